// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

A small counter stage that holds a state word, advances it by one on a clock edge when two count enables are both high, and can be preset from a parallel data word. Every state change happens on the rising clock edge. Two compile-time choices shape the stage. The first picks the counting range: modulo-16 binary, or modulo-10 decade. The second picks how the master reset acts: sampled at the clock edge, or clearing the state at once.

A terminal-count flag lets several stages be joined into a wider counter without extra logic. The flag is combinational and rises when the stage sits at its top value while the second enable is high. To build a chain, feed the first enable of every stage from a common enable. Feed the second enable of each stage from the terminal-count flag of the stage below it. A carry then ripples up through the chain in the same cycle.

In decade mode the states 10 to 15 can only appear through a preset or at power-up. A single enabled count sends any of them back to 0.

Top module: `cascade_counter`

## Requirements
- R1: While `rst_n` is high and `load_n` is low, the next rising clock edge copies `din` into `q`, whatever the enables are.
- R2: In the synchronous-reset variant, a low `rst_n` clears `q` to 0 at the next rising edge, overriding load and enables. `q` does not change between edges.
- R3: In the asynchronous-reset variant, `q` becomes 0 as soon as `rst_n` goes low, with no clock edge.
- R4: When `load_n`, `en_p` and `en_t` are all high and `q` is below the top value, `q` increases by one at the rising edge.
- R5: When `load_n` is high and either enable is low, `q` holds its value across the edge.
- R6: `tc` is high exactly when `en_t` is high and `q` equals the top value, which is 15 in binary mode and 9 in decade mode. `en_p` has no effect on `tc`. `tc` follows its inputs without waiting for a clock edge.
- R7: An enabled count from the top value gives 0.
- R8: In decade mode, an enabled count from any state 10 to 15 gives 0, and `tc` stays low in those states.
- R9: At one edge the priority order is reset, then load, then count, then hold.
- R10: Three binary stages chained through `tc` to `en_t`, with a shared `en_p`, count through all 4096 values of a 12-bit word and wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low master reset (synchronous or asynchronous by parameter) |
| load_n | input | 1 | Active-low parallel preset |
| din | input | WIDTH | Preset data |
| en_p | input | 1 | Count enable that does not gate the terminal count |
| en_t | input | 1 | Count enable that also gates the terminal count |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal-count flag |

## Verification
A decade stage with asynchronous reset is driven from a vector table that mixes presets, counts and every combination of the two enables. This separates a stage that ignores one enable from one that mishandles `tc` gating. Each illegal decade state is preset and then counted once, which separates a one-step return to 0 from a plain increment. Three chained binary stages then run through the full 12-bit range, which exposes any carry that arrives one cycle late. Reset is tried with a pending load in the edge-sampled variant and with no clock edge in the immediate variant, which separates the two reset behaviours.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic { MODE_BINARY = 1'b0, MODE_DECADE = 1'b1 } cnt_mode_e;
  typedef enum logic { RST_SYNC = 1'b0, RST_ASYNC = 1'b1 } cnt_rst_e;
endpackage

// File: rtl/cnt_next_logic.sv
module cnt_next_logic
  import cnt_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = MODE_BINARY
) (
  input  logic [WIDTH-1:0] q,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] d_next,
  output logic             ev_load,
  output logic             ev_count,
  output logic             ev_wrap,
  output logic             ev_illegal
);
  localparam logic [WIDTH-1:0] TOP = (MODE == MODE_DECADE) ? WIDTH'(9) : {WIDTH{1'b1}};

  // Step from a state: the top value and every state above it go to zero.
  function automatic logic [WIDTH-1:0] step_value(input logic [WIDTH-1:0] cur);
    if (cur >= TOP) return '0;
    return cur + WIDTH'(1);
  endfunction

  always_comb begin
    ev_load    = !load_n;
    ev_count   = load_n && en_p && en_t;
    ev_illegal = (q > TOP);
    ev_wrap    = ev_count && (q == TOP);
    if (ev_load)       d_next = din;
    else if (ev_count) d_next = step_value(q);
    else               d_next = q;
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int       WIDTH    = 4,
  parameter cnt_rst_e RST_KIND = RST_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_next,
  output logic [WIDTH-1:0] q
);
  generate
    if (RST_KIND == RST_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d_next;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d_next;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_tc_gen.sv
module cnt_tc_gen
  import cnt_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = MODE_BINARY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = (MODE == MODE_DECADE) ? WIDTH'(9) : {WIDTH{1'b1}};

  function automatic logic at_top(input logic [WIDTH-1:0] cur);
    return cur == TOP;
  endfunction

  assign tc = en_t && at_top(q);

  // R6: the flag never rises while the gating enable is low
  assert_tc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_t |-> !tc);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int        WIDTH    = 4,
  parameter cnt_mode_e MODE     = MODE_BINARY,
  parameter cnt_rst_e  RST_KIND = RST_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = (MODE == MODE_DECADE) ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [WIDTH-1:0] d_next;
  logic ev_load, ev_count, ev_wrap, ev_illegal;

  cnt_next_logic #(.WIDTH(WIDTH), .MODE(MODE)) u_next (
    .q(q), .load_n(load_n), .din(din), .en_p(en_p), .en_t(en_t),
    .d_next(d_next), .ev_load(ev_load), .ev_count(ev_count),
    .ev_wrap(ev_wrap), .ev_illegal(ev_illegal)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .RST_KIND(RST_KIND)) u_reg (
    .clk(clk), .rst_n(rst_n), .d_next(d_next), .q(q)
  );

  cnt_tc_gen #(.WIDTH(WIDTH), .MODE(MODE)) u_tc (
    .clk(clk), .rst_n(rst_n), .q(q), .en_t(en_t), .tc(tc)
  );

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> q == $past(din));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_count && !ev_wrap && !ev_illegal) |=> q == ($past(q) + WIDTH'(1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  assert_tc_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (q == TOP));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> q == '0);

  assert_illegal_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_count && ev_illegal) |=> q == '0);

  assert_illegal_no_tc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |-> !tc);
endmodule

// File: tb/cascade_counter_test.sv
module cascade_counter_test;
  import cnt_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Chain of three binary, edge-reset stages
  logic        c_rst_n, c_load_n, c_en;
  logic [11:0] c_din;
  logic [3:0]  q0, q1, q2;
  logic        tc0, tc1, tc2;

  cascade_counter #(.WIDTH(4), .MODE(MODE_BINARY), .RST_KIND(RST_SYNC)) uut (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[3:0]),
    .en_p(c_en), .en_t(c_en), .q(q0), .tc(tc0));
  cascade_counter #(.WIDTH(4), .MODE(MODE_BINARY), .RST_KIND(RST_SYNC)) u_mid (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[7:4]),
    .en_p(c_en), .en_t(tc0), .q(q1), .tc(tc1));
  cascade_counter #(.WIDTH(4), .MODE(MODE_BINARY), .RST_KIND(RST_SYNC)) u_high (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[11:8]),
    .en_p(c_en), .en_t(tc1), .q(q2), .tc(tc2));

  // Decade stage with immediate reset
  logic       d_rst_n, d_load_n, d_en_p, d_en_t;
  logic [3:0] d_din, d_q;
  logic       d_tc;

  cascade_counter #(.WIDTH(4), .MODE(MODE_DECADE), .RST_KIND(RST_ASYNC)) u_dec (
    .clk(clk), .rst_n(d_rst_n), .load_n(d_load_n), .din(d_din),
    .en_p(d_en_p), .en_t(d_en_t), .q(d_q), .tc(d_tc));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       load_n;
    logic [3:0] din;
    logic       en_p;
    logic       en_t;
    logic [3:0] exp_q;
    logic       exp_tc;
  } vec_t;

  // Decade stage, starting from 0 after reset; results seen after the edge
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd7,  1'b1, 1'b1, 4'd7,  1'b0},  // R1 load
    '{1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  1'b0},  // R4
    '{1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  1'b1},  // R6 top
    '{1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0},  // R7 wrap
    '{1'b1, 4'd0,  1'b0, 1'b1, 4'd0,  1'b0},  // R5
    '{1'b0, 4'd9,  1'b0, 1'b0, 4'd9,  1'b0},  // R1 R6 gated
    '{1'b1, 4'd0,  1'b1, 1'b0, 4'd9,  1'b0},  // R5 R6
    '{1'b1, 4'd0,  1'b0, 1'b1, 4'd9,  1'b1},  // R5 R6 en_p no effect
    '{1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 1'b0},  // R8
    '{1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0},  // R8
    '{1'b0, 4'd15, 1'b1, 1'b1, 4'd15, 1'b0},  // R9 load over count
    '{1'b1, 4'd0,  1'b0, 1'b1, 4'd15, 1'b0},  // R5 R8
    '{1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0},  // R8
    '{1'b1, 4'd0,  1'b1, 1'b1, 4'd1,  1'b0}   // R4
  };

  task automatic dec_step(input logic ld, input logic [3:0] dv, input logic ep, input logic et);
    @(negedge clk);
    d_load_n = ld; d_din = dv; d_en_p = ep; d_en_t = et;
    @(posedge clk);
    #5;
  endtask

  function automatic int chain_val();
    return int'({q2, q1, q0});
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    c_rst_n = 1'b0; c_load_n = 1'b1; c_en = 1'b0; c_din = '0;
    d_rst_n = 1'b0; d_load_n = 1'b1; d_en_p = 1'b0; d_en_t = 1'b0; d_din = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R2 chain reset value", chain_val(), 0);
    chk("R3 decade reset value", int'(d_q), 0);
    @(negedge clk);
    c_rst_n = 1'b1; d_rst_n = 1'b1;

    // Table walk on the decade stage
    for (int i = 0; i < NV; i++) begin
      dec_step(VECS[i].load_n, VECS[i].din, VECS[i].en_p, VECS[i].en_t);
      chk($sformatf("R1/R4/R5/R7/R9 table q vec %0d", i), int'(d_q), int'(VECS[i].exp_q));
      chk($sformatf("R6/R8 table tc vec %0d", i), int'(d_tc), int'(VECS[i].exp_tc));
    end

    // R6: tc follows en_t between edges
    @(negedge clk);
    d_load_n = 1'b0; d_din = 4'd9; d_en_p = 1'b0; d_en_t = 1'b0;
    @(posedge clk); #5;
    d_load_n = 1'b1;
    d_en_t = 1'b1; #1;
    chk("R6 tc rises without edge", int'(d_tc), 1);
    d_en_t = 1'b0; #1;
    chk("R6 tc falls without edge", int'(d_tc), 0);

    // R8: every illegal decade state
    for (int v = 10; v < 16; v++) begin
      dec_step(1'b0, 4'(v), 1'b0, 1'b1);
      chk($sformatf("R8 preset illegal %0d", v), int'(d_q), v);
      chk($sformatf("R8 no tc in illegal %0d", v), int'(d_tc), 0);
      dec_step(1'b1, 4'd0, 1'b1, 1'b1);
      chk($sformatf("R8 recover from %0d", v), int'(d_q), 0);
    end

    // R3: immediate reset with no clock edge
    dec_step(1'b0, 4'd5, 1'b1, 1'b1);
    chk("R3 preset before reset", int'(d_q), 5);
    @(negedge clk);
    #3;
    d_rst_n = 1'b0;
    #2;
    chk("R3 cleared without edge", int'(d_q), 0);
    @(negedge clk);
    d_rst_n = 1'b1; d_load_n = 1'b1; d_en_p = 1'b0;

    // R10 and R1: chain preset near the top, then carry through all stages
    @(negedge clk);
    c_load_n = 1'b0; c_din = 12'hFFE; c_en = 1'b1;
    @(posedge clk); #5;
    chk("R1 chain preset", chain_val(), 12'hFFE);
    c_load_n = 1'b1;
    @(posedge clk); #5;
    chk("R10 chain at top", chain_val(), 12'hFFF);
    chk("R10 top stage tc", int'(tc2), 1);
    @(posedge clk); #5;
    chk("R7 R10 chain wrap", chain_val(), 0);

    // R10: full 12-bit run
    for (int i = 1; i <= 4096; i++) begin
      @(posedge clk); #5;
      chk("R10 chain sequence", chain_val(), i % 4096);
    end

    // R2: edge-sampled reset beats a pending load and does not act between edges
    @(posedge clk); #5;
    chk("R10 chain before reset", chain_val(), 1);
    @(negedge clk);
    c_rst_n = 1'b0; c_load_n = 1'b0; c_din = 12'hABC;
    #3;
    chk("R2 no change between edges", chain_val(), 1);
    @(posedge clk); #5;
    chk("R2 R9 reset over load", chain_val(), 0);
    @(negedge clk);
    c_rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R1 R9 load over count", chain_val(), 12'hABC);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule